// File: doc/BRIEF.md
# Reset-Strap Sampler with LED Drivers

This block owns five shared pins of a PHY-style device that serve two purposes. While the device is held in power-on or hardware reset, every pin is an input and carries a resistor strap. When reset is released, the block latches the five strap levels once. The latched value becomes the device address. From then on, each pin is an output that drives a status LED for one link event.

The polarity of each LED output follows its strap. A pin that was strapped low drives high to light its LED, and a pin that was strapped high drives low. The LED is therefore lit by whichever level differs from the strap, and it stays dark at the strap level. Activity, transmit and receive events are short, so those three pins are stretched to a programmable minimum on-time. A software reset clears that LED state. It does not sample the straps again and it does not return the pins to inputs. An address of zero asks for the management data interface to be tri-stated.

Top module: `strap_led_ctrl`

## Requirements
- R1: Bit i of `status_in` drives pin i only, and bit i of `dev_addr` is the strap level of pin i. The pin order is: 0 activity, 1 collision, 2 link integrity, 3 transmit data, 4 receive data.
- R2: All bits of `pin_oe` are 0 while `por_n` or `hw_rst_n` is low, and they drop as soon as either reset asserts, without waiting for a clock edge.
- R3: `hw_rst_n` passes through a two-flop synchroniser. After both resets are high, `pin_in` is captured into `dev_addr` on the third rising edge. `dev_addr` then holds until the next power-on or hardware reset and reads 0 during reset.
- R4: `pin_oe` goes to all ones on the rising edge after the capture edge, which is the fourth edge after release. The captured value is therefore never the block's own driven level.
- R5: While outputs are enabled, `pin_out[i]` equals `dev_addr[i]` when pin i is dark and `~dev_addr[i]` when pin i is lit.
- R6: Pins 1 and 2 are lit from the edge after which their status bit was sampled high, and they go dark one edge after it is sampled low.
- R7: For pins 0, 3 and 4, a status bit sampled high on edge k lights the pin through edge k+L, where L is `stretch_len` at the last edge with status high. The pin goes dark after edge k+L+1. With L = 0, a one-cycle event lights the pin for exactly one cycle.
- R8: When `sw_rst` is sampled high, `pin_oe` and `dev_addr` stay unchanged, the straps are not sampled, and every pin goes dark after that edge. Stretch timers restart from zero.
- R9: `mdio_hiz` is 1 exactly when `dev_addr` is zero, which includes the time in reset.
- R10: Status inputs are ignored until outputs are enabled. On the edge that sets `pin_oe`, every pin drives its strap level whatever the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| sw_rst | input | 1 | Software reset, active high, synchronous |
| pin_in | input | 5 | Sensed level of the five shared pads |
| status_in | input | 5 | Link status events, order as in R1 |
| stretch_len | input | CNT_W | Minimum extra on-time, in clock cycles, for pins 0, 3 and 4 |
| pin_oe | output | 5 | Output enable per pad |
| pin_out | output | 5 | Driven level per pad |
| dev_addr | output | 5 | Captured strap address |
| mdio_hiz | output | 1 | Tri-state request for the management data interface |

## Verification
Counted from a release of reset between edges, the address is due after the third rising edge and the enables after the fourth. A status or software-reset input sampled on edge k shows on the pins just after edge k, and a stretched pin goes dark after edge k+L+1. The bench drives every input on the falling edge. It advances a behavioural model on each rising edge from those inputs and compares all outputs 3 ns after that edge, so each result is checked in the cycle in which it is due. The asynchronous drop of the enables is checked 1 ns after reset is asserted, before any clock edge.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int unsigned PIN_CNT = 5;
  localparam int unsigned IDX_ACT = 0;
  localparam int unsigned IDX_COL = 1;
  localparam int unsigned IDX_LNK = 2;
  localparam int unsigned IDX_TXD = 3;
  localparam int unsigned IDX_RXD = 4;
  // pins whose events are stretched to a visible on-time
  localparam logic [PIN_CNT-1:0] STRETCH_SEL =
    PIN_CNT'((1 << IDX_ACT) | (1 << IDX_TXD) | (1 << IDX_RXD));
endpackage

// File: rtl/srl_rst_sync.sv
module srl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic ready_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign ready_o = sync_q[STAGES-1];

  // R3: ready never leads the first synchroniser stage
  assert_ready_after_stage_R3: assert property (@(posedge clk) disable iff (!arst_n)
    ready_o |-> sync_q[0]);
endmodule

// File: rtl/srl_strap_cap.sv
module srl_strap_cap #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         ready_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] addr_o,
  output logic         oe_o
);
  logic         ready_q, ready_d;
  logic         cap_q, cap_d;
  logic         oe_q, oe_d;
  logic [W-1:0] addr_q, addr_d;
  logic         rise;

  always_comb begin
    rise    = ready_i & ~ready_q;
    ready_d = ready_i;
    addr_d  = addr_q;
    if (rise) addr_d = pad_i;
    cap_d   = cap_q | rise;
    oe_d    = oe_q | cap_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ready_q <= 1'b0;
      cap_q   <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      ready_q <= ready_d;
      cap_q   <= cap_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
    end
  end

  assign addr_o = addr_q;
  assign oe_o   = oe_q;

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !rise |=> $stable(addr_q));
  assert_oe_after_capture_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !cap_q |-> !oe_q);
  assert_oe_low_unready_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !ready_i |-> !oe_q);
endmodule

// File: rtl/srl_led_stretch.sv
module srl_led_stretch #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             stat_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             led_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             led_q, led_d;
  logic             busy;

  always_comb begin
    busy  = (cnt_q != '0);
    cnt_d = cnt_q;
    led_d = led_q;
    if (clr_i) begin
      cnt_d = '0;
      led_d = 1'b0;
    end else if (en_i) begin
      led_d = stat_i | busy;
      if (stat_i)    cnt_d = len_i;
      else if (busy) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      led_q <= led_d;
    end
  end

  assign led_o = led_q;

  assert_event_lights_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (en_i && !clr_i && stat_i) |=> led_o);
  assert_hold_while_timed_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (en_i && !clr_i && busy) |=> led_o);
  assert_clear_dark_R8: assert property (@(posedge clk) disable iff (!arst_n)
    clr_i |=> (!led_o && cnt_q == '0));
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hw_rst_n,
  input  logic               sw_rst,
  input  logic [PIN_CNT-1:0] pin_in,
  input  logic [PIN_CNT-1:0] status_in,
  input  logic [CNT_W-1:0]   stretch_len,
  output logic [PIN_CNT-1:0] pin_oe,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] dev_addr,
  output logic               mdio_hiz
);
  logic               arst_n;
  logic               ready;
  logic               oe;
  logic [PIN_CNT-1:0] led;

  assign arst_n = por_n & hw_rst_n;

  srl_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .ready_o (ready)
  );

  srl_strap_cap #(.W(PIN_CNT)) u_cap (
    .clk     (clk),
    .arst_n  (arst_n),
    .ready_i (ready),
    .pad_i   (pin_in),
    .addr_o  (dev_addr),
    .oe_o    (oe)
  );

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    if (STRETCH_SEL[i]) begin : g_str
      srl_led_stretch #(.CNT_W(CNT_W)) u_str (
        .clk    (clk),
        .arst_n (arst_n),
        .en_i   (oe),
        .clr_i  (sw_rst),
        .stat_i (status_in[i]),
        .len_i  (stretch_len),
        .led_o  (led[i])
      );
    end else begin : g_dir
      logic lit_q, lit_d;
      always_comb begin
        lit_d = lit_q;
        if (sw_rst)  lit_d = 1'b0;
        else if (oe) lit_d = status_in[i];
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) lit_q <= 1'b0;
        else         lit_q <= lit_d;
      end
      assign led[i] = lit_q;

      assert_level_follow_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (oe && !sw_rst) |=> (led[i] == $past(status_in[i])));
    end
  end

  assign pin_oe   = {PIN_CNT{oe}};
  assign pin_out  = dev_addr ^ led;
  assign mdio_hiz = ~|dev_addr;

  assert_swrst_keeps_pins_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (sw_rst && oe) |=> (pin_oe == '1 && $stable(dev_addr)));
  assert_dark_before_enable_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !oe |-> (led == '0));
endmodule

// File: tb/strap_led_ctrl_tb_top.sv
module strap_led_ctrl_tb_top;
  localparam logic [4:0] STR_PINS = 5'b11001; // R7 pins 0,3,4

  logic       clk;
  logic       por_n, hw_rst_n, sw_rst;
  logic [4:0] strap, status;
  logic [7:0] len;
  logic [4:0] pin_oe, pin_out, dev_addr;
  logic       mdio_hiz;
  logic [4:0] pad;

  int n_chk = 0;
  int n_err = 0;
  bit run_cmp = 1'b1;

  // model state
  int         since_rel;
  logic [4:0] m_addr, m_led;
  logic       m_oe, en_m;
  int         rem [5];

  assign pad = (pin_oe & pin_out) | (~pin_oe & strap);

  strap_led_ctrl dut_i (
    .clk         (clk),
    .por_n       (por_n),
    .hw_rst_n    (hw_rst_n),
    .sw_rst      (sw_rst),
    .pin_in      (pad),
    .status_in   (status),
    .stretch_len (len),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .dev_addr    (dev_addr),
    .mdio_hiz    (mdio_hiz)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!por_n || !hw_rst_n) begin
      since_rel = 0;
      m_addr = '0;
      m_oe = 1'b0;
      m_led = '0;
      for (int i = 0; i < 5; i++) rem[i] = 0;
    end else begin
      en_m = m_oe;
      for (int i = 0; i < 5; i++) begin
        if (sw_rst) begin
          rem[i] = 0;
          m_led[i] = 1'b0;
        end else if (en_m) begin
          if (STR_PINS[i]) begin
            if (status[i]) rem[i] = int'(len) + 1;
            else if (rem[i] > 0) rem[i] = rem[i] - 1;
            m_led[i] = (rem[i] > 0);
          end else begin
            m_led[i] = status[i];
          end
        end
      end
      if (since_rel < 10) since_rel++;
      if (since_rel == 3) m_addr = strap;
      if (since_rel == 4) m_oe = 1'b1;
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #3;
    if (run_cmp) begin
      chk("R2/R4 pin_oe", 32'(pin_oe), 32'({5{m_oe}}));
      chk("R3 dev_addr", 32'(dev_addr), 32'(m_addr));
      chk("R9 mdio_hiz", 32'(mdio_hiz), 32'(m_addr == 5'd0));
      if (m_oe) chk("R5 R6 R7 R8 pin_out", 32'(pin_out), 32'(m_addr ^ m_led));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) act=timeout exp=done");
    finish_run();
  end

  task automatic random_phase(input int cycles, input bit use_sw);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      status = 5'($urandom) & 5'($urandom) & 5'($urandom);
      sw_rst = use_sw && ($urandom % 40 == 0);
      if ($urandom % 50 == 0) len = 8'($urandom % 7);
    end
    @(negedge clk);
    status = '0;
    sw_rst = 1'b0;
  endtask

  initial begin
    por_n = 1'b0; hw_rst_n = 1'b1; sw_rst = 1'b0;
    strap = 5'b10110; status = '0; len = 8'd3;
    repeat (3) @(negedge clk);
    chk("R2 oe low in power-on reset", 32'(pin_oe), 32'h0);
    chk("R9 hiz in reset", 32'(mdio_hiz), 32'h1);
    status = 5'b11111;
    por_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R3 address captured on third edge", 32'(dev_addr), 32'(5'b10110));
    chk("R4 oe still low on capture edge", 32'(pin_oe), 32'h0);
    chk("R1 addr bit order", 32'(dev_addr[4]), 32'h1);
    @(posedge clk); #3;
    chk("R4 oe high one edge after capture", 32'(pin_oe), 32'h1f);
    chk("R10 status ignored before enable", 32'(pin_out), 32'(5'b10110));
    @(posedge clk); #3;
    chk("R5 lit pins drive inverse of strap", 32'(pin_out), 32'(~5'b10110 & 5'h1f));
    @(negedge clk); status = '0;
    @(posedge clk); #3;
    chk("R6 R7 direct pins dark, stretched lit", 32'(pin_out), 32'(5'b10110 ^ STR_PINS));
    repeat (2) @(posedge clk); #3;
    chk("R7 stretched pins lit through k+L", 32'(pin_out), 32'(5'b10110 ^ STR_PINS));
    @(posedge clk); #3;
    chk("R7 stretched pins dark after k+L+1", 32'(pin_out), 32'(5'b10110));

    @(negedge clk); status = 5'b00010;
    @(posedge clk); #3;
    chk("R1 collision drives pin 1 only", 32'(pin_out), 32'(5'b10110 ^ 5'b00010));
    @(negedge clk); status = 5'b00100;
    @(posedge clk); #3;
    chk("R6 link pin lit", 32'(pin_out[2]), 32'h0);
    @(negedge clk); status = '0;
    @(posedge clk); #3;
    chk("R6 link pin dark one edge later", 32'(pin_out[2]), 32'h1);

    random_phase(400, 1'b0);

    @(negedge clk); status = 5'b00001;
    @(negedge clk); sw_rst = 1'b1;
    @(posedge clk); #3;
    chk("R8 oe kept in software reset", 32'(pin_oe), 32'h1f);
    chk("R8 address kept in software reset", 32'(dev_addr), 32'(5'b10110));
    chk("R8 pins dark in software reset", 32'(pin_out), 32'(5'b10110));
    @(negedge clk); sw_rst = 1'b0; status = '0;

    random_phase(300, 1'b1);

    @(negedge clk); hw_rst_n = 1'b0;
    #1;
    chk("R2 oe drops at once on hardware reset", 32'(pin_oe), 32'h0);
    strap = 5'b00000;
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b1;
    repeat (5) @(posedge clk); #3;
    chk("R9 zero address requests tri-state", 32'(mdio_hiz), 32'h1);
    random_phase(100, 1'b1);

    @(negedge clk); hw_rst_n = 1'b0;
    strap = 5'b01001; len = 8'd0;
    repeat (2) @(negedge clk);
    hw_rst_n = 1'b1;
    repeat (5) @(posedge clk); #3;
    chk("R3 new straps after hardware reset", 32'(dev_addr), 32'(5'b01001));
    chk("R9 nonzero address releases tri-state", 32'(mdio_hiz), 32'h0);
    @(negedge clk); status = 5'b01000;
    @(negedge clk); status = '0;
    @(posedge clk); #3;
    chk("R7 zero stretch gives one-cycle on-time", 32'(pin_out), 32'(5'b01001));
    random_phase(300, 1'b1);

    repeat (3) @(posedge clk);
    run_cmp = 1'b0;
    finish_run();
  end
endmodule